// File: doc/BRIEF.md
# SCSI DMA Adapter Register Front End

This block is the host-facing control and status logic of a SCSI host adapter. It sits between a 16-bit host register bus and an 8-bit SCSI protocol controller that has a data FIFO. It holds a control register, a DMA address and a DMA count that are written as 16-bit halves, a 32-bit FIFO byte counter, and an interrupt vector register. It drives the active-low resets for the FIFO and for the controller. It counts bytes moved between the FIFO and the controller, and it reports completion and error status.

The controller's interrupt reaches the host only while DMA is enabled. To arm reselection interrupts, software therefore sets DMA enable with a zero count. The controller's own registers can be reached through a window in the host address space, but only while DMA is off. A residual register returns the number of bytes not transferred. On a send that ends early, it corrects for the one byte that the data path moves too many.

Top module: `scsi_dma_ctl`

## Requirements
- R1: After reset, the control/status word (offset 0) reads 0x0000, both reset outputs are low and `host_irq` is low.
- R2: Control bit 0 drives `fifo_rst_n` and control bit 1 drives `ctl_rst_n`, both active low: writing a 1 releases a reset and writing a 0 asserts it. Control bit 2 is DMA enable, bit 3 is send direction (drives `dma_send`), and bit 4 is host interrupt enable. All five bits read back at bits 4..0.
- R3: The DMA address high (offset 1), DMA address low (2), DMA count high (3), DMA count low (4) and vector word (7) read back the last 16-bit value written to them. In the vector word, the low byte is the vector and the high byte is the address modifier.
- R4: A write to FIFO count high (offset 5) also loads the same value into DMA count high (offset 3).
- R5: The FIFO count is 32 bits, with offset 5 as the high half and offset 6 as the low half. Each cycle with `byte_xfer` high, DMA enabled and a non-zero count, it decrements by one and borrows across the halves. With DMA disabled, `byte_xfer` is ignored.
- R6: The DMA-done flag (status bit 9) sets when a decrement brings the count to zero. Writing offset 0 with bit 9 set clears it.
- R7: A `dma_conflict` pulse sets status bit 10 and a `dma_bus_err` pulse sets status bit 11. Both bits are sticky, and while either is set it holds bit 9 set, so writing 1 to bit 9 does not clear it. Both clear only while the FIFO reset is asserted. That reset also clears bit 9 and the FIFO count.
- R8: Status bit 8 (controller interrupt pending) equals `ctl_irq`, suppressed while `fifo_has_data` is high or the FIFO count is non-zero.
- R9: `host_irq` = interrupt enable AND (bit 9 OR (DMA enable AND bit 8)). With DMA disabled, a controller interrupt never reaches the host.
- R10: Addresses with bit 4 set form the controller window. `ctl_sel` follows `hb_sel` there only while DMA is disabled, and a read there returns `ctl_rdata` in the low byte.
- R11: The residual (offset 8 high, offset 9 low) equals the FIFO count plus one when send is selected and the count is non-zero and below the last programmed FIFO count. In every other case it equals the FIFO count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel | input | 1 | Host bus cycle select |
| hb_wr | input | 1 | Host write (1) or read (0) |
| hb_addr | input | 5 | Word address; bit 4 selects the controller window |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data (combinational) |
| host_irq | output | 1 | Interrupt to host |
| fifo_rst_n | output | 1 | FIFO reset, active low |
| ctl_rst_n | output | 1 | SCSI controller reset, active low |
| dma_en | output | 1 | DMA engine enable |
| dma_send | output | 1 | Direction: 1 memory to SCSI |
| ctl_sel | output | 1 | Controller register select |
| ctl_rdata | input | 8 | Controller register read data |
| ctl_irq | input | 1 | Controller interrupt request |
| fifo_has_data | input | 1 | FIFO not empty |
| byte_xfer | input | 1 | One byte moved between FIFO and controller |
| dma_conflict | input | 1 | DMA conflict event pulse |
| dma_bus_err | input | 1 | System-bus error event pulse |

## Verification
A wrong count state appears on the next read of the FIFO count or the residual. It also changes `host_irq` one cycle after the decrement that should have reached zero. A gating fault, such as the controller interrupt passing with DMA off or while the FIFO holds data, shows on `host_irq` in the same cycle as the input change. A stuck error bit shows as a done flag that write-one-to-clear cannot clear, or as one that clears without a FIFO reset. The window guard is probed with DMA both on and off, and the residual is read in send and receive directions at three count positions.

// File: rtl/scsi_dma_ctl.sv
module scsi_dma_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_sel,
  input  logic          hb_wr,
  input  logic [AW-1:0] hb_addr,
  input  logic [15:0]   hb_wdata,
  output logic [15:0]   hb_rdata,
  output logic          host_irq,
  output logic          fifo_rst_n,
  output logic          ctl_rst_n,
  output logic          dma_en,
  output logic          dma_send,
  output logic          ctl_sel,
  input  logic [7:0]    ctl_rdata,
  input  logic          ctl_irq,
  input  logic          fifo_has_data,
  input  logic          byte_xfer,
  input  logic          dma_conflict,
  input  logic          dma_bus_err
);
  localparam int WIN = AW - 1;

  logic [4:0]  ctrl;
  logic [15:0] addr_hi, addr_lo, cnt_hi, cnt_lo, ivam;
  logic [31:0] fifo_cnt, prog_len, resid;
  logic        dma_ip, err_conf, err_bus, ctl_ip, irq_en;
  logic        win, wr_reg, dec, hit_zero;

  assign fifo_rst_n = ctrl[0];
  assign ctl_rst_n  = ctrl[1];
  assign dma_en     = ctrl[2];
  assign dma_send   = ctrl[3];
  assign irq_en     = ctrl[4];

  assign win     = hb_addr[WIN];
  assign wr_reg  = hb_sel && hb_wr && !win;
  assign ctl_sel = hb_sel && win && !dma_en;

  assign ctl_ip   = ctl_irq && !fifo_has_data && (fifo_cnt == 32'd0);
  assign host_irq = irq_en && (dma_ip || (dma_en && ctl_ip));

  assign dec      = byte_xfer && dma_en && (fifo_cnt != 32'd0);
  assign hit_zero = dec && (fifo_cnt == 32'd1);

  assign resid = (dma_send && fifo_cnt != 32'd0 && fifo_cnt < prog_len)
                 ? fifo_cnt + 32'd1 : fifo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      addr_hi <= '0;
      addr_lo <= '0;
      cnt_hi  <= '0;
      cnt_lo  <= '0;
      ivam    <= '0;
    end else if (wr_reg) begin
      case (hb_addr[3:0])
        4'd0: ctrl    <= hb_wdata[4:0];
        4'd1: addr_hi <= hb_wdata;
        4'd2: addr_lo <= hb_wdata;
        4'd3: cnt_hi  <= hb_wdata;
        4'd4: cnt_lo  <= hb_wdata;
        4'd5: cnt_hi  <= hb_wdata;
        4'd7: ivam    <= hb_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_cnt <= '0;
      prog_len <= '0;
    end else if (!fifo_rst_n) begin
      fifo_cnt <= '0;
    end else if (wr_reg && hb_addr[3:0] == 4'd5) begin
      fifo_cnt[31:16] <= hb_wdata;
      prog_len[31:16] <= hb_wdata;
    end else if (wr_reg && hb_addr[3:0] == 4'd6) begin
      fifo_cnt[15:0] <= hb_wdata;
      prog_len[15:0] <= hb_wdata;
    end else if (dec) begin
      fifo_cnt <= fifo_cnt - 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_conf <= 1'b0;
      err_bus  <= 1'b0;
      dma_ip   <= 1'b0;
    end else if (!fifo_rst_n) begin
      err_conf <= 1'b0;
      err_bus  <= 1'b0;
      dma_ip   <= 1'b0;
    end else begin
      if (dma_conflict) err_conf <= 1'b1;
      if (dma_bus_err)  err_bus  <= 1'b1;
      if (hit_zero || dma_conflict || dma_bus_err || err_conf || err_bus)
        dma_ip <= 1'b1;
      else if (wr_reg && hb_addr[3:0] == 4'd0 && hb_wdata[9])
        dma_ip <= 1'b0;
    end
  end

  always_comb begin
    hb_rdata = '0;
    if (win) begin
      hb_rdata = {8'h00, ctl_rdata};
    end else begin
      case (hb_addr[3:0])
        4'd0: hb_rdata = {4'b0, err_bus, err_conf, dma_ip, ctl_ip, 3'b0, ctrl};
        4'd1: hb_rdata = addr_hi;
        4'd2: hb_rdata = addr_lo;
        4'd3: hb_rdata = cnt_hi;
        4'd4: hb_rdata = cnt_lo;
        4'd5: hb_rdata = fifo_cnt[31:16];
        4'd6: hb_rdata = fifo_cnt[15:0];
        4'd7: hb_rdata = ivam;
        4'd8: hb_rdata = resid[31:16];
        4'd9: hb_rdata = resid[15:0];
        default: hb_rdata = '0;
      endcase
    end
  end
endmodule

module scsi_dma_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hb_sel,
  input logic        hb_wr,
  input logic        host_irq,
  input logic        dma_en,
  input logic        ctl_sel,
  input logic        fifo_rst_n,
  input logic        fifo_has_data,
  input logic        byte_xfer,
  input logic        dma_ip,
  input logic        err_conf,
  input logic        err_bus,
  input logic [31:0] fifo_cnt
);
  a_r10_window_guard: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel |-> !dma_en);

  a_r9_ctl_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !dma_ip) |-> dma_en);

  a_r8_fifo_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_has_data && !dma_ip) |-> !host_irq);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_conf && fifo_rst_n) |=> err_conf);

  a_r7_err_forces_ip: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_conf || err_bus) && fifo_rst_n) |=> dma_ip);

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_xfer && dma_en && fifo_cnt != 32'd0 && fifo_rst_n && !(hb_sel && hb_wr))
    |=> fifo_cnt == $past(fifo_cnt) - 32'd1);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && fifo_rst_n && !(hb_sel && hb_wr)) |=> $stable(fifo_cnt));
endmodule

bind scsi_dma_ctl scsi_dma_ctl_chk u_chk (.*);

// File: tb/scsi_dma_ctl_test.sv
module scsi_dma_ctl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        hb_sel = 0, hb_wr = 0;
  logic [4:0]  hb_addr = '0;
  logic [15:0] hb_wdata = '0;
  logic [15:0] hb_rdata;
  logic        host_irq, fifo_rst_n, ctl_rst_n, dma_en, dma_send, ctl_sel;
  logic [7:0]  ctl_rdata = 8'h00;
  logic        ctl_irq = 0, fifo_has_data = 0, byte_xfer = 0;
  logic        dma_conflict = 0, dma_bus_err = 0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        smp = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  scsi_dma_ctl uut (.*);

  always @(negedge clk) begin
    if (smp && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (hb_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got %h expected %h", t, hb_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1 hb_sel = 1; hb_wr = 1; hb_addr = a; hb_wdata = d;
    @(posedge clk); #1 hb_sel = 0; hb_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(posedge clk); #1 hb_sel = 1; hb_wr = 0; hb_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); smp = 1;
    @(posedge clk); #1 smp = 0; hb_sel = 0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  task automatic xfer(input int n);
    @(posedge clk); #1 byte_xfer = 1;
    repeat (n) @(posedge clk);
    #1 byte_xfer = 0;
  endtask

  task automatic probe_win(input logic e, input string t);
    @(posedge clk); #1 hb_sel = 1; hb_wr = 0; hb_addr = 5'h12;
    #2 chk(ctl_sel, e, t);
    @(posedge clk); #1 hb_sel = 0;
  endtask

  task automatic pulse_err(input bit bus);
    @(posedge clk); #1 if (bus) dma_bus_err = 1; else dma_conflict = 1;
    @(posedge clk); #1 dma_bus_err = 0; dma_conflict = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(5'd0, 16'h0000, "R1");
    chk(fifo_rst_n, 0, "R1"); chk(ctl_rst_n, 0, "R1"); chk(host_irq, 0, "R1");
    // R2 release resets
    wr(5'd0, 16'h0003);
    chk(fifo_rst_n, 1, "R2"); chk(ctl_rst_n, 1, "R2");
    rd(5'd0, 16'h0003, "R2");
    // R3 readback
    wr(5'd1, 16'h00AB); wr(5'd2, 16'h1234); wr(5'd4, 16'h4321); wr(5'd7, 16'h3D55);
    rd(5'd1, 16'h00AB, "R3"); rd(5'd2, 16'h1234, "R3");
    rd(5'd4, 16'h4321, "R3"); rd(5'd7, 16'h3D55, "R3");
    // R4 fifo high also hits dma count high
    wr(5'd3, 16'h1111); wr(5'd5, 16'h0002);
    rd(5'd3, 16'h0002, "R4"); rd(5'd5, 16'h0002, "R4");
    // R5 decrement, ignored with DMA off
    wr(5'd6, 16'h0000);
    xfer(1);
    rd(5'd5, 16'h0002, "R5"); rd(5'd6, 16'h0000, "R5");
    wr(5'd0, 16'h0007);
    chk(dma_en, 1, "R2");
    xfer(1);
    rd(5'd5, 16'h0001, "R5"); rd(5'd6, 16'hFFFF, "R5");
    // R10 window blocked with DMA on
    probe_win(0, "R10");
    // R6 done flag
    wr(5'd5, 16'h0000); wr(5'd6, 16'h0002);
    xfer(2);
    rd(5'd0, 16'h0207, "R6");
    chk(host_irq, 0, "R9");
    wr(5'd0, 16'h0017);
    chk(host_irq, 1, "R9");
    wr(5'd0, 16'h0217);
    chk(host_irq, 0, "R6");
    rd(5'd0, 16'h0017, "R6");
    // R8 / R9 controller interrupt gating
    @(posedge clk); #1 ctl_irq = 1;
    #2 chk(host_irq, 1, "R9");
    rd(5'd0, 16'h0117, "R8");
    @(posedge clk); #1 fifo_has_data = 1;
    #2 chk(host_irq, 0, "R8");
    rd(5'd0, 16'h0017, "R8");
    @(posedge clk); #1 fifo_has_data = 0;
    wr(5'd0, 16'h0013);
    chk(host_irq, 0, "R9");
    rd(5'd0, 16'h0113, "R8");
    @(posedge clk); #1 ctl_irq = 0;
    // R10 window open with DMA off
    ctl_rdata = 8'h5A;
    probe_win(1, "R10");
    rd(5'h13, 16'h005A, "R10");
    // R7 sticky errors
    pulse_err(0);
    rd(5'd0, 16'h0613, "R7");
    wr(5'd0, 16'h0213);
    rd(5'd0, 16'h0613, "R7");
    chk(host_irq, 1, "R7");
    wr(5'd0, 16'h0012);
    wr(5'd0, 16'h0013);
    rd(5'd0, 16'h0013, "R7");
    pulse_err(1);
    rd(5'd0, 16'h0A13, "R7");
    wr(5'd0, 16'h0012);
    wr(5'd0, 16'h0013);
    rd(5'd0, 16'h0013, "R7");
    // R11 residual, R12-style direction output covered under R2
    wr(5'd0, 16'h001B);
    chk(dma_send, 1, "R2");
    wr(5'd5, 16'h0000); wr(5'd6, 16'h0010);
    rd(5'd9, 16'h0010, "R11");
    wr(5'd0, 16'h001F);
    xfer(3);
    rd(5'd9, 16'h000E, "R11"); rd(5'd8, 16'h0000, "R11");
    rd(5'd6, 16'h000D, "R5");
    wr(5'd0, 16'h0017);
    rd(5'd9, 16'h000D, "R11");
    wr(5'd0, 16'h001F);
    xfer(13);
    rd(5'd9, 16'h0000, "R11");
    rd(5'd0, 16'h021F, "R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule